// File: doc/BRIEF.md
# Serial Control Port Master

This block is the master side of a slow serial control port used to set up a display-type peripheral. It drives four wires: an active-low enable, a gated serial clock, a data line toward the device and a data line back from the device. A client hands over one word per transaction through a valid/ready request interface. The block shifts the word out most-significant bit first and collects the same number of bits returned by the device. It then reports the captured word with a one-cycle valid pulse.

All port timing is derived from the fast system clock through parameters: the system clock frequency, the highest allowed serial clock rate (500 kHz), the enable guard time (2 µs) and the word length. Each derived count carries one extra system cycle of margin. The serial clock toggles only while enable is low. A guard interval separates the enable edges from the first and last clock edges, and enable stays high for at least one guard interval between transactions. The block changes its output bit on the rising edge of the serial clock, so the device sees half a clock period of setup and of hold around its falling-edge capture. Returned data is sampled on the falling edge, half a period after the device launched it.

An active-low power-down input overrides everything else. It forces enable high, stops the clock low and drives the output line low, and it ignores the returned-data line. A transaction that is cut short ends with an abort pulse instead of a valid pulse. A fresh guard interval must then pass before a new request is accepted.

Top module: `sctl_master`

## Requirements
- R1: After reset, with power-down inactive (`pwr_dn_n` = 1): `port_en_n` = 1, `port_sck` = 0, `port_dout` = 0, `busy` = 0 and `req_ready` = 1.
- R2: Inside a transaction every high phase and every low phase of `port_sck` lasts exactly HALF system cycles, with HALF = ceil(system cycles in 1 µs) + 1 (201 at 200 MHz). Exactly WORD_W rising edges occur per transaction.
- R3: `port_sck` is never high while `port_en_n` is high.
- R4: The first rising edge of `port_sck` comes exactly GUARD system cycles after `port_en_n` falls, with GUARD = ceil(system cycles in 2 µs) + 1 (401 at 200 MHz).
- R5: `port_en_n` rises exactly GUARD system cycles after the last falling edge of `port_sck`.
- R6: After a transaction `port_en_n` stays high for at least GUARD cycles. `req_ready` returns exactly GUARD cycles after `port_en_n` rises, and a request already waiting is accepted one cycle later.
- R7: `port_dout` changes only together with a rising edge of `port_sck` while enable is low. The k-th rising edge (k from 0) presents bit WORD_W-1-k of the request word.
- R8: `port_din` is sampled on each falling edge of `port_sck`, first sample into the MSB. `rsp_valid` pulses for one cycle in the cycle `port_en_n` rises, and `rsp_data` then holds the sampled word.
- R9: `busy` is high from the accepting cycle until `req_ready` returns. `req_ready` is never high while `busy` is high. A request offered while busy is ignored: it starts no transaction and does not alter the word being sent.
- R10: One cycle after `pwr_dn_n` is seen low, `port_en_n` = 1, `port_sck` = 0 and `port_dout` = 0. A cut-short transaction gives one `rsp_abort` pulse and no `rsp_valid`.
- R11: After `pwr_dn_n` returns high, `req_ready` rises exactly GUARD cycles after the last cycle in which power-down was sampled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_dn_n | input | 1 | Active-low power-down; aborts and holds the port idle |
| req_valid | input | 1 | Request word offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_data | input | WORD_W | Word to shift out, MSB first |
| rsp_valid | output | 1 | One-cycle pulse: transaction finished |
| rsp_abort | output | 1 | One-cycle pulse: transaction cut short by power-down |
| rsp_data | output | WORD_W | Word captured from the device |
| busy | output | 1 | Transaction or closing guard in progress |
| port_en_n | output | 1 | Active-low port enable |
| port_sck | output | 1 | Gated serial clock |
| port_dout | output | 1 | Serial data toward the device |
| port_din | input | 1 | Serial data from the device |

## Verification
Every port result has a fixed distance from the event that causes it. The first clock rise comes GUARD cycles after enable falls, and each clock phase lasts HALF cycles. Enable rises GUARD cycles after the last fall, together with the response pulse, and ready returns GUARD cycles after that. After power-down the outputs are forced one cycle after the low sample, and ready comes back GUARD cycles after the last low sample. The bench samples every port half a cycle after the falling system clock edge and timestamps each wire change with a free-running cycle counter. It then compares the gaps between timestamps with these exact counts, not with a tolerance band. A device model in the bench launches its reply bit when it sees the rising serial clock, so a capture made on the wrong edge shows up as a wrong response word.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHI,
        ST_SLO,
        ST_TRAIL,
        ST_GAP
    } sctl_state_e;

    // system cycles covering a time in ns, rounded up, plus one cycle of margin
    function automatic int unsigned cycles_for_ns(longint unsigned hz, longint unsigned ns);
        longint unsigned raw;
        raw = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
        return int'(raw) + 1;
    endfunction

endpackage

// File: rtl/sctl_pacer.sv
module sctl_pacer #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } pace_t;

    pace_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load) begin
            nxt_d.cnt = load_val;
        end else if (cur_q.cnt != '0) begin
            nxt_d.cnt = cur_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign zero = (cur_q.cnt == '0);
endmodule

// File: rtl/sctl_shift.sv
module sctl_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         launch,
    input  logic         capture,
    input  logic         din,
    output logic         tx_msb,
    output logic [W-1:0] rx_word
);
    typedef struct packed {
        logic [W-1:0] tx;
        logic [W-1:0] rx;
    } shreg_t;

    shreg_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load) begin
            nxt_d.tx = load_word;
        end else if (launch) begin
            nxt_d.tx = {cur_q.tx[W-2:0], 1'b0};
        end
        if (capture) begin
            nxt_d.rx = {cur_q.rx[W-2:0], din};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign tx_msb  = cur_q.tx[W-1];
    assign rx_word = cur_q.rx;
endmodule

// File: rtl/sctl_master.sv
module sctl_master
    import sctl_pkg::*;
#(
    parameter int unsigned SYS_CLK_HZ = 200_000_000,
    parameter int unsigned SCK_MAX_HZ = 500_000,
    parameter int unsigned GUARD_NS   = 2000,
    parameter int          WORD_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_dn_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [WORD_W-1:0] req_data,
    output logic              rsp_valid,
    output logic              rsp_abort,
    output logic [WORD_W-1:0] rsp_data,
    output logic              busy,
    output logic              port_en_n,
    output logic              port_sck,
    output logic              port_dout,
    input  logic              port_din
);
    localparam int unsigned HALF_NS = 1_000_000_000 / (2 * SCK_MAX_HZ);
    localparam int unsigned HALF    = cycles_for_ns(SYS_CLK_HZ, HALF_NS);
    localparam int unsigned GUARD   = cycles_for_ns(SYS_CLK_HZ, GUARD_NS);
    localparam int unsigned SPAN    = (HALF > GUARD) ? HALF : GUARD;
    localparam int          CW      = $clog2(SPAN + 1);
    localparam int          BW      = $clog2(WORD_W);

    typedef struct packed {
        sctl_state_e       state;
        logic              en_n;
        logic              sck;
        logic              dout;
        logic [BW-1:0]     bitcnt;
        logic              rsp_valid;
        logic              rsp_abort;
        logic [WORD_W-1:0] rsp_data;
    } ctl_t;

    ctl_t cur_q, nxt_d;

    logic          pace_load;
    logic [CW-1:0] pace_val;
    logic          pace_zero;
    logic          sh_load;
    logic          sh_launch;
    logic          sh_capture;
    logic          sh_msb;
    logic [WORD_W-1:0] sh_rx;

    sctl_pacer #(.CW(CW)) u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pace_load),
        .load_val (pace_val),
        .zero     (pace_zero)
    );

    sctl_shift #(.W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_word (req_data),
        .launch    (sh_launch),
        .capture   (sh_capture),
        .din       (port_din),
        .tx_msb    (sh_msb),
        .rx_word   (sh_rx)
    );

    always_comb begin
        nxt_d           = cur_q;
        nxt_d.rsp_valid = 1'b0;
        nxt_d.rsp_abort = 1'b0;
        pace_load       = 1'b0;
        pace_val        = '0;
        sh_load         = 1'b0;
        sh_launch       = 1'b0;
        sh_capture      = 1'b0;

        if (!pwr_dn_n) begin
            nxt_d.rsp_abort = (cur_q.state != ST_IDLE) && (cur_q.state != ST_GAP);
            nxt_d.state     = ST_GAP;
            nxt_d.en_n      = 1'b1;
            nxt_d.sck       = 1'b0;
            nxt_d.dout      = 1'b0;
            pace_load       = 1'b1;
            pace_val        = CW'(GUARD - 1);
        end else begin
            unique case (cur_q.state)
                ST_IDLE: begin
                    if (req_valid) begin
                        sh_load      = 1'b1;
                        nxt_d.en_n   = 1'b0;
                        nxt_d.bitcnt = '0;
                        nxt_d.state  = ST_LEAD;
                        pace_load    = 1'b1;
                        pace_val     = CW'(GUARD - 1);
                    end
                end
                ST_LEAD, ST_SLO: begin
                    if (pace_zero) begin
                        nxt_d.sck   = 1'b1;
                        nxt_d.dout  = sh_msb;
                        sh_launch   = 1'b1;
                        nxt_d.state = ST_SHI;
                        pace_load   = 1'b1;
                        pace_val    = CW'(HALF - 1);
                    end
                end
                ST_SHI: begin
                    if (pace_zero) begin
                        nxt_d.sck  = 1'b0;
                        sh_capture = 1'b1;
                        pace_load  = 1'b1;
                        if (cur_q.bitcnt == BW'(WORD_W - 1)) begin
                            nxt_d.state = ST_TRAIL;
                            pace_val    = CW'(GUARD - 1);
                        end else begin
                            nxt_d.bitcnt = cur_q.bitcnt + 1'b1;
                            nxt_d.state  = ST_SLO;
                            pace_val     = CW'(HALF - 1);
                        end
                    end
                end
                ST_TRAIL: begin
                    if (pace_zero) begin
                        nxt_d.en_n      = 1'b1;
                        nxt_d.dout      = 1'b0;
                        nxt_d.rsp_valid = 1'b1;
                        nxt_d.rsp_data  = sh_rx;
                        nxt_d.state     = ST_GAP;
                        pace_load       = 1'b1;
                        pace_val        = CW'(GUARD - 1);
                    end
                end
                ST_GAP: begin
                    if (pace_zero) nxt_d.state = ST_IDLE;
                end
                default: nxt_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q       <= '0;
            cur_q.state <= ST_IDLE;
            cur_q.en_n  <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign req_ready = (cur_q.state == ST_IDLE) && pwr_dn_n;
    assign busy      = (cur_q.state != ST_IDLE);
    assign rsp_valid = cur_q.rsp_valid;
    assign rsp_abort = cur_q.rsp_abort;
    assign rsp_data  = cur_q.rsp_data;
    assign port_en_n = cur_q.en_n;
    assign port_sck  = cur_q.sck;
    assign port_dout = cur_q.dout;

    // R3
    sck_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_sck |-> !port_en_n);

    // R2
    sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_dn_n && !pace_zero) |=> $stable(port_sck));

    // R7
    dout_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(port_dout) && !port_en_n) |-> $rose(port_sck));

    // R10
    pd_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_dn_n |=> (port_en_n && !port_sck && !port_dout));

    // R9
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !busy);

    // R8
    rsp_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (port_en_n && $past(!port_en_n)));

    // R10
    rsp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && rsp_abort));
endmodule

// File: tb/sctl_master_test.sv
`timescale 1ns/1ps
module sctl_master_test;
    localparam int W       = 16;
    localparam int HALF_C  = 1000 / 5 + 1;
    localparam int GUARD_C = 2000 / 5 + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_dn_n = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [W-1:0]  req_data = '0;
    logic          rsp_valid;
    logic          rsp_abort;
    logic [W-1:0]  rsp_data;
    logic          busy;
    logic          port_en_n;
    logic          port_sck;
    logic          port_dout;
    logic          port_din;

    always #2.5 clk = ~clk;

    sctl_master uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_dn_n  (pwr_dn_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_data  (req_data),
        .rsp_valid (rsp_valid),
        .rsp_abort (rsp_abort),
        .rsp_data  (rsp_data),
        .busy      (busy),
        .port_en_n (port_en_n),
        .port_sck  (port_sck),
        .port_dout (port_dout),
        .port_din  (port_din)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor state, updated at each falling system clock edge
    logic         psck = 1'b0;
    logic         pen = 1'b1;
    logic         pdout = 1'b0;
    int           t_en_fall = 0, t_en_rise = 0, last_fall = 0, last_sck_t = 0, rise0_t = 0;
    int           nrise = 0, n_fall_en = 0, n_rsp = 0, n_abort = 0;
    int           phase_err = 0, window_err = 0, glitch = 0;
    logic [W-1:0] dout_bits = '0;
    logic [W-1:0] rsp_word = '0;
    logic [W-1:0] dev_word = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            port_din <= 1'b0;
        end else begin
            if (pen && !port_en_n) begin
                t_en_fall = cyc;
                nrise = 0;
                n_fall_en++;
            end
            if (!pen && port_en_n) t_en_rise = cyc;
            if (port_sck && port_en_n) window_err++;
            if (port_dout !== pdout && !port_en_n && !(port_sck && !psck)) glitch++;
            if (port_sck != psck) begin
                if (!port_en_n && !(port_sck && nrise == 0) && (cyc - last_sck_t != HALF_C))
                    phase_err++;
                last_sck_t = cyc;
                if (port_sck) begin
                    if (nrise == 0) rise0_t = cyc;
                    if (nrise < W) begin
                        dout_bits[W-1-nrise] = port_dout;
                        port_din <= dev_word[W-1-nrise];
                    end
                    nrise++;
                end else begin
                    last_fall = cyc;
                end
            end
            if (rsp_valid) begin
                rsp_t_upd();
            end
            if (rsp_abort) n_abort++;
        end
        psck  = port_sck;
        pen   = port_en_n;
        pdout = port_dout;
    end

    int rsp_t = 0;
    task automatic rsp_t_upd();
        rsp_t    = cyc;
        rsp_word = rsp_data;
        n_rsp++;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #0.5;
    endtask

    task automatic wait_ready(output int t);
        while (!req_ready) step();
        t = cyc;
    endtask

    // offer one word and return once it has been accepted
    task automatic offer(input logic [W-1:0] tx, input logic [W-1:0] dev);
        int t;
        wait_ready(t);
        dev_word  = dev;
        req_data  = tx;
        req_valid = 1'b1;
        step();
        req_valid = 1'b0;
    endtask

    task automatic check_done(input logic [W-1:0] tx, input logic [W-1:0] dev, input int r0);
        int tr;
        while (n_rsp == r0) step();
        chk(busy == 1'b1, "R9", "busy at response", busy, 1);
        chk(rise0_t - t_en_fall == GUARD_C, "R4", "enable to first rise", rise0_t - t_en_fall, GUARD_C);
        chk(nrise == W, "R2", "rising edge count", nrise, W);
        chk(phase_err == 0, "R2", "phase length errors", phase_err, 0);
        chk(t_en_rise - last_fall == GUARD_C, "R5", "last fall to enable rise", t_en_rise - last_fall, GUARD_C);
        chk(window_err == 0, "R3", "clock high outside window", window_err, 0);
        chk(dout_bits == tx, "R7", "word seen by device", dout_bits, tx);
        chk(glitch == 0, "R7", "dout changes off rising edge", glitch, 0);
        chk(rsp_word == dev, "R8", "captured word", rsp_word, dev);
        chk(rsp_t == t_en_rise, "R8", "response cycle", rsp_t, t_en_rise);
        wait_ready(tr);
        chk(tr == t_en_rise + GUARD_C, "R6", "ready after enable rise", tr, t_en_rise + GUARD_C);
        chk(busy == 1'b0, "R9", "busy cleared with ready", busy, 0);
    endtask

    task automatic t_reset();
        chk(port_en_n == 1'b1, "R1", "enable after reset", port_en_n, 1);
        chk(port_sck == 1'b0, "R1", "clock after reset", port_sck, 0);
        chk(port_dout == 1'b0, "R1", "dout after reset", port_dout, 0);
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    endtask

    task automatic t_basic(input logic [W-1:0] tx, input logic [W-1:0] dev);
        int r0;
        r0 = n_rsp;
        offer(tx, dev);
        chk(busy == 1'b1, "R9", "busy after accept", busy, 1);
        check_done(tx, dev, r0);
    endtask

    task automatic t_back_to_back();
        int r0, f0, rise_prev;
        r0 = n_rsp;
        offer(16'h1234, 16'hFEDC);
        req_data  = 16'h8001;
        req_valid = 1'b1;
        while (n_rsp == r0) step();
        dev_word  = 16'h7FFE;
        rise_prev = t_en_rise;
        f0 = n_fall_en;
        while (n_fall_en == f0) step();
        req_valid = 1'b0;
        chk(t_en_fall - rise_prev == GUARD_C + 1, "R6", "enable high gap", t_en_fall - rise_prev, GUARD_C + 1);
        check_done(16'h8001, 16'h7FFE, r0 + 1);
    endtask

    task automatic t_ignored();
        int r0, f0, tr;
        bit rdy_seen;
        r0 = n_rsp;
        f0 = n_fall_en;
        offer(16'hC3A5, 16'h0F0F);
        while (nrise < 3) step();
        rdy_seen  = 1'b0;
        req_data  = 16'h5555;
        req_valid = 1'b1;
        repeat (4) begin
            step();
            if (req_ready) rdy_seen = 1'b1;
        end
        req_valid = 1'b0;
        chk(rdy_seen == 1'b0, "R9", "ready while busy", rdy_seen, 0);
        check_done(16'hC3A5, 16'h0F0F, r0);
        repeat (10) step();
        chk(n_fall_en == f0 + 1, "R9", "transactions started", n_fall_en - f0, 1);
        wait_ready(tr);
    endtask

    task automatic t_power_down();
        int r0, a0, ce, tr;
        r0 = n_rsp;
        a0 = n_abort;
        offer(16'hFFFF, 16'hAAAA);
        while (nrise < 5) step();
        pwr_dn_n = 1'b0;
        step();
        chk(port_en_n == 1'b1, "R10", "enable forced high", port_en_n, 1);
        chk(port_sck == 1'b0, "R10", "clock stopped", port_sck, 0);
        chk(port_dout == 1'b0, "R10", "dout forced low", port_dout, 0);
        chk(n_abort == a0 + 1, "R10", "abort pulse", n_abort - a0, 1);
        chk(req_ready == 1'b0, "R10", "ready during power-down", req_ready, 0);
        step();
        chk(n_abort == a0 + 1, "R10", "single abort pulse", n_abort - a0, 1);
        pwr_dn_n = 1'b1;
        ce = cyc;
        wait_ready(tr);
        chk(tr == ce + GUARD_C, "R11", "ready after power-down", tr, ce + GUARD_C);
        chk(n_rsp == r0, "R10", "no response on abort", n_rsp - r0, 0);
        chk(window_err == 0, "R3", "clock high outside window", window_err, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_basic(16'hA5C3, 16'h3C5A);
        t_basic(16'h0001, 16'h8000);
        t_back_to_back();
        t_ignored();
        t_power_down();
        t_basic(16'h6B2D, 16'h94D2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule